// File: doc/BRIEF.md
# DMA Channel Request Arbiter

This block decides which DMA channel may move its next element. On every clock it looks at each channel's configuration word, the element count held in its control word, and the peripheral request lines. From the channels that qualify it picks the one with the lowest index. The pick is handed to the transfer engine as a registered grant: a valid flag, a binary index and a one-hot vector.

A channel qualifies when all of these hold: it is switched on, it is not halted, its count is nonzero, and the peripheral requests named by its flow type are present. Nothing qualifies while the global enable is low. Flow types 4 to 7 hand flow control to a peripheral, which this block does not support. A channel set to one of those types is never granted and raises an unsupported flag instead.

The arbiter has a two-state machine. In `ARB_IDLE` no grant is shown. The transition *take* happens when the global enable is high, at least one channel qualifies and the engine is not busy; it latches the winner and moves to `ARB_HOLD`. In `ARB_HOLD` the grant is driven and kept frozen. The transition *release* happens when the engine pulses done, and returns the machine to `ARB_IDLE`. All other cases stay in the current state: *wait* in `ARB_IDLE` and *keep* in `ARB_HOLD`.

Top module: `dma_req_arbiter`

## Requirements
- R1: While `glob_en` is low, no new grant is issued, however many channels qualify.
- R2: A channel is a candidate only if configuration bit 0 (enable) is 1 and configuration bit 18 (halt) is 0.
- R3: A channel whose count field, control bits [11:0], is zero is not eligible.
- R4: The request seen for a peripheral is the OR of `req_single` and `req_burst`. The source peripheral number is configuration bits [5:1] and the destination peripheral number is bits [10:6]. A peripheral number of `NUM_PERIPH` or more never has its request present.
- R5: The flow type is configuration bits [13:11]. Type 0 needs no request. Type 1 needs the destination request. Type 2 needs the source request. Type 3 needs both.
- R6: A channel with flow type 4 to 7 is never granted. Its `unsupported` bit is high whenever it is enabled and not halted, whatever its count, the requests or `glob_en`.
- R7: When several channels are eligible, the one with the lowest index is granted.
- R8: A grant is taken only in `ARB_IDLE` while `eng_busy` is low. Outputs show it from the clock edge after the inputs that qualified it.
- R9: While `grant_valid` is high, `grant_idx` and `grant_onehot` stay constant until `eng_done` is sampled high, whatever the other inputs do. At the edge that samples `eng_done`, `grant_valid` falls for at least one cycle.
- R10: After reset, `grant_valid` is 0, `grant_idx` is 0 and `grant_onehot` is 0. While valid, `grant_onehot` has exactly bit `grant_idx` set; otherwise it is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| glob_en | input | 1 | Global enable for the whole controller |
| ch_cfg | input | NUM_CH*32 | Configuration words; channel i occupies bits [32*i+31:32*i] |
| ch_ctl | input | NUM_CH*32 | Control words; the count is in bits [11:0] of each |
| req_single | input | NUM_PERIPH | Single-transfer request lines |
| req_burst | input | NUM_PERIPH | Burst request lines |
| eng_busy | input | 1 | Transfer engine is occupied; blocks a new grant |
| eng_done | input | 1 | One-cycle pulse that ends the current grant |
| grant_valid | output | 1 | A grant is being held |
| grant_idx | output | IDX_W | Index of the granted channel |
| grant_onehot | output | NUM_CH | One-hot form of the granted channel |
| unsupported | output | NUM_CH | Channel is enabled with a peripheral-controlled flow type |

## Verification
The bench builds the arbiter with `NUM_CH = 4` and `NUM_PERIPH = 16`. Four channels are enough to put the winner at the bottom, in the middle and at the top of the scan, and to let a lower channel lose because of a missing request, a halt or a zero count. Sixteen request lines let one vector give a destination number of 20. That number lies beyond the request vector, so the case where a peripheral can never be present is exercised with every request line high.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    localparam int WORD_W    = 32;
    localparam int CNT_W     = 12;
    localparam int PID_W     = 5;
    localparam int FLOW_W    = 3;

    localparam int EN_BIT    = 0;
    localparam int SRC_LSB   = 1;
    localparam int DST_LSB   = 6;
    localparam int FLOW_LSB  = 11;
    localparam int HALT_BIT  = 18;

    typedef enum logic {
        ARB_IDLE = 1'b0,
        ARB_HOLD = 1'b1
    } arb_state_e;

    typedef enum logic [FLOW_W-1:0] {
        FLOW_FREE   = 3'd0,
        FLOW_DSTREQ = 3'd1,
        FLOW_SRCREQ = 3'd2,
        FLOW_BOTH   = 3'd3
    } flow_e;

endpackage

// File: rtl/dma_chan_qualify.sv
module dma_chan_qualify
    import dma_arb_pkg::*;
#(
    parameter int NUM_PERIPH = 16
) (
    input  logic [WORD_W-1:0]     cfg,
    input  logic [WORD_W-1:0]     ctl,
    input  logic [NUM_PERIPH-1:0] req_eff,
    output logic                  eligible,
    output logic                  unsup
);

    logic              live;
    logic [PID_W-1:0]  src_id;
    logic [PID_W-1:0]  dst_id;
    logic [FLOW_W-1:0] flow;
    logic [CNT_W-1:0]  count;
    logic [NUM_PERIPH-1:0] src_sh;
    logic [NUM_PERIPH-1:0] dst_sh;
    logic              src_hit;
    logic              dst_hit;
    logic              flow_ok;

    assign live   = cfg[EN_BIT] & ~cfg[HALT_BIT];
    assign src_id = cfg[SRC_LSB +: PID_W];
    assign dst_id = cfg[DST_LSB +: PID_W];
    assign flow   = cfg[FLOW_LSB +: FLOW_W];
    assign count  = ctl[CNT_W-1:0];

    // Out-of-range peripheral numbers shift every bit away: request absent.
    assign src_sh  = req_eff >> src_id;
    assign dst_sh  = req_eff >> dst_id;
    assign src_hit = src_sh[0];
    assign dst_hit = dst_sh[0];

    always_comb begin
        flow_ok = 1'b0;
        unique case (flow)
            FLOW_FREE:   flow_ok = 1'b1;
            FLOW_DSTREQ: flow_ok = dst_hit;
            FLOW_SRCREQ: flow_ok = src_hit;
            FLOW_BOTH:   flow_ok = src_hit & dst_hit;
            default:     flow_ok = 1'b0;
        endcase
    end

    assign unsup    = live & flow[FLOW_W-1];
    assign eligible = live & ~flow[FLOW_W-1] & (count != '0) & flow_ok;

endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
    parameter int N = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  cand,
    output logic          any,
    output logic [IW-1:0] idx,
    output logic [N-1:0]  onehot
);

    always_comb begin
        idx    = '0;
        onehot = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) begin
                idx    = IW'(i);
                onehot = N'(1) << i;
            end
        end
    end

    assign any = |cand;

endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
    import dma_arb_pkg::*;
#(
    parameter int NUM_CH     = 8,
    parameter int NUM_PERIPH = 16,
    localparam int IDX_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     glob_en,
    input  logic [NUM_CH*WORD_W-1:0] ch_cfg,
    input  logic [NUM_CH*WORD_W-1:0] ch_ctl,
    input  logic [NUM_PERIPH-1:0]    req_single,
    input  logic [NUM_PERIPH-1:0]    req_burst,
    input  logic                     eng_busy,
    input  logic                     eng_done,
    output logic                     grant_valid,
    output logic [IDX_W-1:0]         grant_idx,
    output logic [NUM_CH-1:0]        grant_onehot,
    output logic [NUM_CH-1:0]        unsupported
);

    logic [NUM_PERIPH-1:0] req_eff;
    logic [NUM_CH-1:0]     elig_vec;
    logic [NUM_CH-1:0]     cand_vec;
    logic                  pick_any;
    logic [IDX_W-1:0]      pick_idx;
    logic [NUM_CH-1:0]     pick_oh;
    logic                  take;
    arb_state_e            state_q;
    arb_state_e            state_d;

    assign req_eff = req_single | req_burst;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        dma_chan_qualify #(
            .NUM_PERIPH (NUM_PERIPH)
        ) u_qual (
            .cfg      (ch_cfg[c*WORD_W +: WORD_W]),
            .ctl      (ch_ctl[c*WORD_W +: WORD_W]),
            .req_eff  (req_eff),
            .eligible (elig_vec[c]),
            .unsup    (unsupported[c])
        );
    end

    assign cand_vec = glob_en ? elig_vec : '0;

    dma_prio_pick #(
        .N (NUM_CH)
    ) u_pick (
        .cand   (cand_vec),
        .any    (pick_any),
        .idx    (pick_idx),
        .onehot (pick_oh)
    );

    assign take = (state_q == ARB_IDLE) && pick_any && !eng_busy;

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE: if (take)     state_d = ARB_HOLD;
            ARB_HOLD: if (eng_done) state_d = ARB_IDLE;
            default:                state_d = ARB_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ARB_IDLE;
        else        state_q <= state_d;
    end

    // Grant outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grant_valid  <= 1'b0;
            grant_idx    <= '0;
            grant_onehot <= '0;
        end else begin
            unique case (state_q)
                ARB_IDLE: begin
                    if (take) begin
                        grant_valid  <= 1'b1;
                        grant_idx    <= pick_idx;
                        grant_onehot <= pick_oh;
                    end
                end
                ARB_HOLD: begin
                    if (eng_done) begin
                        grant_valid  <= 1'b0;
                        grant_onehot <= '0;
                    end
                end
                default: begin
                    grant_valid  <= 1'b0;
                    grant_onehot <= '0;
                end
            endcase
        end
    end

    // R1, R8: a grant appears only after an enabled, idle-engine cycle
    a_r1_r8_grant_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_valid) |-> $past(glob_en && !eng_busy));

    // R6: unsupported channels are never eligible
    a_r6_unsup_not_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        (unsupported & elig_vec) == '0);

    // R7: granted channel was eligible and no lower one was
    a_r7_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_valid) |-> ((($past(elig_vec) & grant_onehot) != '0) &&
                                (($past(elig_vec) & (grant_onehot - 1'b1)) == '0)));

    // R9: grant frozen until done
    a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !eng_done) |=> (grant_valid && $stable(grant_idx) && $stable(grant_onehot)));

    // R9: done drops the grant
    a_r9_done_release: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && eng_done) |=> !grant_valid);

    // R10: encoding consistency
    a_r10_onehot_valid: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (($countones(grant_onehot) == 1) && grant_onehot[grant_idx]));

    a_r10_onehot_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_valid |-> (grant_onehot == '0));

endmodule

// File: tb/dma_req_arbiter_test.sv
`timescale 1ns/1ps
module dma_req_arbiter_test;

    localparam int  TB_CH   = 4;
    localparam int  TB_PER  = 16;
    localparam time CLK_P   = 20ns;
    localparam int  NVEC    = 17;

    function automatic logic [31:0] mk(bit en, bit halt, int flow, int src, int dst);
        return {13'b0, halt, 4'b0, 3'(flow), 5'(dst), 5'(src), en};
    endfunction

    localparam logic [31:0] Z  = 32'h0;
    localparam logic [31:0] F0 = {13'b0, 1'b0, 4'b0, 3'd0, 5'd0, 5'd0, 1'b1};

    typedef struct packed {
        logic         glob;
        logic [127:0] cfg;
        logic [47:0]  cnt;
        logic [15:0]  rs;
        logic [15:0]  rb;
        logic         ev;
        logic [1:0]   ei;
        logic [3:0]   eu;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{1'b1, {Z, Z, Z, F0},                         {12'd0,12'd0,12'd0,12'd5}, 16'h0000, 16'h0000, 1'b1, 2'd0, 4'h0}, // R5 type0
        '{1'b1, {Z, Z, F0, mk(0,0,0,0,0)},             {12'd0,12'd0,12'd1,12'd5}, 16'h0000, 16'h0000, 1'b1, 2'd1, 4'h0}, // R2 off
        '{1'b1, {Z, F0, Z, mk(1,1,0,0,0)},             {12'd0,12'd2,12'd0,12'd5}, 16'h0000, 16'h0000, 1'b1, 2'd2, 4'h0}, // R2 halt
        '{1'b1, {Z, Z, F0, F0},                        {12'd0,12'd0,12'd3,12'd0}, 16'h0000, 16'h0000, 1'b1, 2'd1, 4'h0}, // R3
        '{1'b1, {Z, Z, F0, mk(1,0,1,0,3)},             {12'd0,12'd0,12'd1,12'd1}, 16'h0000, 16'h0000, 1'b1, 2'd1, 4'h0}, // R5 no dst
        '{1'b1, {Z, Z, Z, mk(1,0,1,0,3)},              {12'd0,12'd0,12'd0,12'd1}, 16'h0008, 16'h0000, 1'b1, 2'd0, 4'h0}, // R5 dst
        '{1'b1, {Z, Z, Z, mk(1,0,2,7,0)},              {12'd0,12'd0,12'd0,12'd1}, 16'h0000, 16'h0080, 1'b1, 2'd0, 4'h0}, // R4 burst
        '{1'b1, {F0, Z, Z, mk(1,0,2,7,3)},             {12'd1,12'd0,12'd0,12'd1}, 16'h0008, 16'h0000, 1'b1, 2'd3, 4'h0}, // R5 src
        '{1'b1, {Z, Z, Z, mk(1,0,3,5,9)},              {12'd0,12'd0,12'd0,12'd1}, 16'h0020, 16'h0000, 1'b0, 2'd0, 4'h0}, // R5 both miss
        '{1'b1, {Z, Z, Z, mk(1,0,3,5,9)},              {12'd0,12'd0,12'd0,12'd1}, 16'h0020, 16'h0200, 1'b1, 2'd0, 4'h0}, // R5 both
        '{1'b1, {Z, F0, Z, mk(1,0,4,0,0)},             {12'd0,12'd1,12'd0,12'd5}, 16'h0000, 16'h0000, 1'b1, 2'd2, 4'h1}, // R6
        '{1'b1, {Z, Z, mk(1,0,5,0,0), Z},              {12'd0,12'd0,12'd0,12'd0}, 16'h0000, 16'h0000, 1'b0, 2'd0, 4'h2}, // R6 cnt0
        '{1'b1, {Z, Z, mk(1,1,7,0,0), Z},              {12'd0,12'd0,12'd4,12'd0}, 16'h0000, 16'h0000, 1'b0, 2'd0, 4'h0}, // R6 halted
        '{1'b0, {Z, Z, Z, F0},                         {12'd0,12'd0,12'd0,12'd5}, 16'h0000, 16'h0000, 1'b0, 2'd0, 4'h0}, // R1
        '{1'b1, {F0, Z, F0, Z},                        {12'd1,12'd0,12'd1,12'd0}, 16'h0000, 16'h0000, 1'b1, 2'd1, 4'h0}, // R7
        '{1'b1, {Z, Z, F0, mk(1,0,1,0,20)},            {12'd0,12'd0,12'd1,12'd1}, 16'hFFFF, 16'hFFFF, 1'b1, 2'd1, 4'h0}, // R4 range
        '{1'b1, {Z, Z, Z, Z},                          {12'd0,12'd0,12'd0,12'd0}, 16'h0000, 16'h0000, 1'b0, 2'd0, 4'h0}  // idle
    };

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                glob_en = 1'b0;
    logic [TB_CH*32-1:0] ch_cfg = '0;
    logic [TB_CH*32-1:0] ch_ctl = '0;
    logic [TB_PER-1:0]   req_single = '0;
    logic [TB_PER-1:0]   req_burst = '0;
    logic                eng_busy = 1'b0;
    logic                eng_done = 1'b0;
    logic                grant_valid;
    logic [1:0]          grant_idx;
    logic [TB_CH-1:0]    grant_onehot;
    logic [TB_CH-1:0]    unsupported;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    dma_req_arbiter #(.NUM_CH(TB_CH), .NUM_PERIPH(TB_PER)) uut (
        .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .ch_cfg(ch_cfg), .ch_ctl(ch_ctl),
        .req_single(req_single), .req_burst(req_burst), .eng_busy(eng_busy),
        .eng_done(eng_done), .grant_valid(grant_valid), .grant_idx(grant_idx),
        .grant_onehot(grant_onehot), .unsupported(unsupported)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_counts(logic [47:0] c);
        for (int i = 0; i < TB_CH; i++)
            ch_ctl[i*32 +: 32] = {20'h0, c[i*12 +: 12]};
    endtask

    task automatic release_grant();
        @(negedge clk);
        eng_done = 1'b1; glob_en = 1'b0; ch_cfg = '0;
        @(negedge clk);
        eng_done = 1'b0;
    endtask

    task automatic run_tests();
        repeat (3) @(negedge clk);
        chk("R10 reset valid", 32'(grant_valid), 32'd0);
        chk("R10 reset idx", 32'(grant_idx), 32'd0);
        chk("R10 reset onehot", 32'(grant_onehot), 32'd0);
        rst_n = 1'b1;

        for (int v = 0; v < NVEC; v++) begin
            glob_en    = VECS[v].glob;
            ch_cfg     = VECS[v].cfg;
            set_counts(VECS[v].cnt);
            req_single = VECS[v].rs;
            req_burst  = VECS[v].rb;
            @(negedge clk);
            chk($sformatf("R8 vec%0d valid", v), 32'(grant_valid), 32'(VECS[v].ev));
            chk($sformatf("R6 vec%0d unsupported", v), 32'(unsupported), 32'(VECS[v].eu));
            if (VECS[v].ev) begin
                chk($sformatf("R7 vec%0d idx", v), 32'(grant_idx), 32'(VECS[v].ei));
                chk($sformatf("R10 vec%0d onehot", v), 32'(grant_onehot), 32'(1) << VECS[v].ei);
            end else begin
                chk($sformatf("R10 vec%0d onehot idle", v), 32'(grant_onehot), 32'd0);
            end
            release_grant();
        end

        // R8: busy engine blocks a new grant
        eng_busy = 1'b1; glob_en = 1'b1;
        ch_cfg = {Z, Z, Z, F0}; set_counts({12'd0, 12'd0, 12'd1, 12'd1});
        repeat (3) @(negedge clk);
        chk("R8 busy blocks", 32'(grant_valid), 32'd0);
        eng_busy = 1'b0;
        @(negedge clk);
        chk("R8 grant after busy", 32'(grant_valid), 32'd1);
        chk("R8 idx after busy", 32'(grant_idx), 32'd0);

        // R9: grant frozen while inputs change
        ch_cfg = {Z, Z, F0, Z}; eng_busy = 1'b1; glob_en = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 hold valid", 32'(grant_valid), 32'd1);
        chk("R9 hold idx", 32'(grant_idx), 32'd0);
        chk("R9 hold onehot", 32'(grant_onehot), 32'd1);
        eng_busy = 1'b0; glob_en = 1'b1; eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0;
        chk("R9 done drops valid", 32'(grant_valid), 32'd0);
        @(negedge clk);
        chk("R9 regrant valid", 32'(grant_valid), 32'd1);
        chk("R9 regrant idx", 32'(grant_idx), 32'd1);
        release_grant();

        // R1: dropping glob_en with eligible channel
        glob_en = 1'b0; ch_cfg = {F0, F0, F0, F0}; set_counts({12'd1, 12'd1, 12'd1, 12'd1});
        repeat (2) @(negedge clk);
        chk("R1 global off", 32'(grant_valid), 32'd0);
    endtask

    initial begin
        bit wd_hit;
        wd_hit = 1'b0;
        fork
            run_tests();
            begin
                #(CLK_P * 200000);
                wd_hit = 1'b1;
            end
        join_any
        disable fork;
        if (wd_hit) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule